// File: doc/BRIEF.md
# Four-Lane Extended-Range Float Comparator

This block compares two 128-bit vectors as four separate 32-bit single-precision lanes and returns, for every lane, a 32-bit mask that is either all ones (condition true) or all zeros (condition false). One operation covers all four lanes. The operation is either equality or a greater-than test of operand A against operand B, picked by a one-bit opcode.

The number format is an extended-range single precision. It has no infinity and no NaN. An exponent of all ones is an ordinary finite value of very large magnitude. Because of this, equality is a plain pattern match except for zeros, and ordering is a sign-magnitude comparison. A lane whose exponent field is zero counts as a zero of its own sign, whatever its mantissa holds. Both signs of zero are the same value.

Inputs are taken when `in_valid` is high. The packed masks appear on `result` one clock later, with `out_valid` high for that cycle. Lane 0 is the most significant 32 bits. The result register holds its value between accepted operations.

Top module: `xr_cmp4`

## Requirements
- R1: Lane i occupies bits [127-32*i : 96-32*i] of `a`, `b` and `result` (lane 0 is bits 127:96), and each lane's result depends only on that lane's operands.
- R2: Every 32-bit lane of `result` is either 0xFFFFFFFF (true) or 0x00000000 (false).
- R3: With `op`=0 (equal), two lanes with identical bit patterns compare equal, including patterns whose exponent field (bits 30:23) is all ones; distinct non-zero patterns compare unequal.
- R4: +0 (0x00000000) and -0 (0x80000000) compare equal, and neither is greater than the other.
- R5: A lane whose exponent field is zero is treated as zero of its own sign for both operations, regardless of its mantissa (bits 22:0).
- R6: With `op`=1 (greater-than) and operands of different effective sign, the lane is true exactly when A is the non-negative one.
- R7: With `op`=1 and both operands positive, the lane is true exactly when A's magnitude (bits 30:0) is larger; an exponent of all ones ranks above every smaller pattern, and equal values give false.
- R8: With `op`=1 and both operands negative, the lane is true exactly when A's magnitude is smaller.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low; `result` shows the masks for the inputs that were accepted.
- R10: While `in_valid` is low, `result` keeps its previous value, whatever `a`, `b` and `op` do.
- R11: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 1 | 0 = equal, 1 = A greater than B |
| a | input | 128 | Operand A, four 32-bit lanes, lane 0 at the top |
| b | input | 128 | Operand B, four 32-bit lanes, lane 0 at the top |
| out_valid | output | 1 | `result` holds a new answer this cycle |
| result | output | 128 | Four 32-bit lane masks |

## Verification
The compare logic has no state, so a wrong decision in any lane appears on `result` in the very next cycle after the operation is accepted. It shows as a full 32-bit lane with the wrong polarity, or as a lane that is only partly set. Faults in the register stage show at the ports in a different way. A wrong valid timing or a missing hold shows within one clock as an `out_valid` pulse that is off by a cycle, or as `result` changing while no input was accepted. The sign and zero handling is tested with lanes that differ only in the sign bit, in a zero exponent, or in an all-ones exponent, so that a plain signed or unsigned compare would give a different answer.

// File: rtl/xr_cmp_pkg.sv
package xr_cmp_pkg;
  localparam int unsigned XR_LANE_W = 32;
  localparam int unsigned XR_EXP_W  = 8;

  typedef enum logic {
    XR_OP_EQ = 1'b0,
    XR_OP_GT = 1'b1
  } xr_op_e;
endpackage

// File: rtl/xr_lane_cmp.sv
module xr_lane_cmp #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned EXP_W  = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              gt_sel_i,
  output logic [LANE_W-1:0] mask_o
);
  localparam int unsigned MAG_W = LANE_W - 1;

  // magnitude with a zero exponent folded to zero
  function automatic logic [MAG_W-1:0] eff_mag(input logic [LANE_W-1:0] w);
    if (w[MAG_W-1 -: EXP_W] == '0) return '0;
    return w[MAG_W-1:0];
  endfunction

  // sign that counts only when the value is not a zero
  function automatic logic eff_neg(input logic [LANE_W-1:0] w);
    return w[LANE_W-1] && (eff_mag(w) != '0);
  endfunction

  logic [MAG_W-1:0] mag_a, mag_b;
  logic             neg_a, neg_b;
  logic             mag_same, mag_a_big, mag_a_small;
  logic             eq_hit, gt_hit;

  always_comb begin
    mag_a       = eff_mag(a_i);
    mag_b       = eff_mag(b_i);
    neg_a       = eff_neg(a_i);
    neg_b       = eff_neg(b_i);
    mag_same    = (mag_a == mag_b);
    mag_a_big   = (mag_a > mag_b);
    mag_a_small = (mag_a < mag_b);
    eq_hit      = mag_same && (neg_a == neg_b);
    if (neg_a != neg_b)  gt_hit = neg_b;
    else if (neg_a)      gt_hit = mag_a_small;
    else                 gt_hit = mag_a_big;
    mask_o = {LANE_W{gt_sel_i ? gt_hit : eq_hit}};
  end

  // equal and greater-than never both hold for one pair (R6, R7, R8)
  always_comb begin
    p_eq_gt_excl_r6: assert (!(eq_hit && gt_hit))
      else $error("lane: equal and greater both true");
  end

  // identical patterns are equal and never greater (R3)
  always_comb begin
    if (a_i == b_i) begin
      p_self_eq_r3: assert (eq_hit && !gt_hit)
        else $error("lane: identical patterns misjudged");
    end
  end
endmodule

// File: rtl/xr_cmp_pipe.sv
module xr_cmp_pipe #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/xr_cmp4.sv
module xr_cmp4
  import xr_cmp_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = XR_LANE_W,
  parameter int unsigned EXP_W  = XR_EXP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    op,
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES*LANE_W-1:0] b,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] result
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              gt_sel;
  logic [DATA_W-1:0] mask_next;

  assign gt_sel = (op == XR_OP_GT);

  // lane 0 sits at the most significant end (R1)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned HI = DATA_W - 1 - i * LANE_W;
    xr_lane_cmp #(
      .LANE_W (LANE_W),
      .EXP_W  (EXP_W)
    ) u_lane (
      .a_i      (a[HI -: LANE_W]),
      .b_i      (b[HI -: LANE_W]),
      .gt_sel_i (gt_sel),
      .mask_o   (mask_next[HI -: LANE_W])
    );
  end

  xr_cmp_pipe #(
    .W (DATA_W)
  ) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .load_i  (in_valid),
    .d_i     (mask_next),
    .valid_o (out_valid),
    .q_o     (result)
  );

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  p_same_eq_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !gt_sel && a == b) |=> (result == '1));

  p_same_not_gt_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gt_sel && a == b) |=> (result == '0));
endmodule

// File: tb/xr_cmp4_bench.sv
`timescale 1ns/1ps
module xr_cmp4_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         op;
  logic [127:0] a, b;
  logic         out_valid;
  logic [127:0] result;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  xr_cmp4 u_xr_cmp4 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result)
  );

  // {op, a, b, expected lane bits (lane0 first)}
  localparam logic [260:0] VEC [0:7] = '{
    {1'b0, 128'h3F800000_3F800000_7F800000_7FC00000,
           128'h3F800000_3F800001_7F800000_7FC00000, 4'b1011},
    {1'b0, 128'h00000000_00000001_007FFFFF_80400000,
           128'h80000000_80000000_00000000_00000000, 4'b1111},
    {1'b0, 128'h3F800000_C0000000_00800000_FF800000,
           128'hBF800000_C0000000_00000000_7F800000, 4'b0100},
    {1'b1, 128'h00000000_80000000_00000001_00000000,
           128'h80000000_00000000_00000000_80000001, 4'b0000},
    {1'b1, 128'h3F800000_BF800000_3F800000_00000000,
           128'h BF800000_3F800000_00000000_BF800000, 4'b1011},
    {1'b1, 128'h40000000_3F800000_7F800000_7FFFFFFF,
           128'h3F800000_40000000_7F7FFFFF_7F800000, 4'b1011},
    {1'b1, 128'hBF800000_C0000000_FF800000_80000001,
           128'hC0000000_BF800000_FF7FFFFF_BF800000, 4'b1001},
    {1'b1, 128'h3F800000_BF800000_00800000_80800000,
           128'h3F800000_BF800000_00000000_00000000, 4'b0010}
  };

  function automatic string row_req(input int i);
    case (i)
      0: return "R3 R1 R2";
      1: return "R4 R5";
      2: return "R3 R5";
      3: return "R4 R5";
      4: return "R6";
      5: return "R7";
      6: return "R8 R5";
      default: return "R7 R6";
    endcase
  endfunction

  // ordering key: signed integer, zero exponent maps to 0
  function automatic longint key(input logic [31:0] w);
    longint m;
    m = (w[30:23] == 8'h00) ? 0 : longint'(w[30:0]);
    return w[31] ? -m : m;
  endfunction

  function automatic logic [127:0] model(input logic o, input logic [127:0] x,
                                         input logic [127:0] y);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) begin
      longint kx, ky;
      logic   t;
      kx = key(x[127-32*l -: 32]);
      ky = key(y[127-32*l -: 32]);
      t  = o ? (kx > ky) : (kx == ky);
      r[127-32*l -: 32] = t ? 32'hFFFFFFFF : 32'h0;
    end
    return r;
  endfunction

  function automatic logic [127:0] expand(input logic [3:0] e);
    return {{32{e[3]}}, {32{e[2]}}, {32{e[1]}}, {32{e[0]}}};
  endfunction

  task automatic check(input string req, input logic [127:0] got,
                       input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one operation at a falling edge, sample at the next falling edge
  task automatic run_op(input logic o, input logic [127:0] x,
                        input logic [127:0] y, output logic v,
                        output logic [127:0] r);
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    in_valid = 1'b0;
    v = out_valid;
    r = result;
  endtask

  function automatic logic [31:0] gen_word();
    logic [31:0] w;
    w = $urandom;
    case ($urandom % 6)
      0: w[30:23] = 8'h00;
      1: w[30:23] = 8'hFF;
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic         v;
    logic [127:0] r;
    rst = 1'b1; in_valid = 1'b0; op = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", {127'b0, out_valid}, 128'h0);
    check("R11 result in reset", result, 128'h0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      run_op(VEC[i][260], VEC[i][259:132], VEC[i][131:4], v, r);
      check({row_req(i), " valid"}, {127'b0, v}, 128'h1);
      check(row_req(i), r, expand(VEC[i][3:0]));
    end

    // R9: valid drops the cycle after in_valid falls
    @(negedge clk);
    check("R9 out_valid low after idle", {127'b0, out_valid}, 128'h0);

    // R10: inputs move while in_valid low; result must not follow
    r = result;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op = ~op; a = {4{32'h3F800000}}; b = {4{32'hBF800000}};
    end
    @(negedge clk);
    check("R10 hold while idle", result, r);

    // randomized sweep against the ordering-key model (R1 R2 R3..R8)
    for (int n = 0; n < 60; n++) begin
      logic [127:0] x, y;
      logic         o;
      for (int l = 0; l < 4; l++) begin
        logic [31:0] wa, wb;
        wa = gen_word();
        case ($urandom % 4)
          0: wb = wa;
          1: wb = wa ^ 32'h80000000;
          2: wb = wa + 32'd1;
          default: wb = gen_word();
        endcase
        x[127-32*l -: 32] = wa;
        y[127-32*l -: 32] = wb;
      end
      o = $urandom % 2;
      run_op(o, x, y, v, r);
      check("R1 R2 sweep", r, model(o, x, y));
    end

    // R9 back-to-back: two accepted ops in consecutive cycles
    @(negedge clk);
    in_valid = 1'b1; op = 1'b0; a = {4{32'h40000000}}; b = {4{32'h40000000}};
    @(negedge clk);
    check("R9 first of pair", result, {128{1'b1}});
    op = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second of pair", result, 128'h0);
    check("R9 valid still high", {127'b0, out_valid}, 128'h1);

    // R11: reset mid-run clears registers
    run_op(1'b0, '0, '0, v, r);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 result after reset", result, 128'h0);
    check("R11 valid after reset", {127'b0, out_valid}, 128'h0);
    rst = 1'b0;

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule